// File: doc/BRIEF.md
# Receive status and error tally

This block records the outcome of every received frame in a network controller's receive path and keeps three error tally counters for network management. The receive datapath reports each frame through single-cycle strobes (frame start, frame end, FIFO overflow) plus condition levels. The condition levels are the CRC verdict, a flag for frames that end off a byte boundary, receive-buffer availability and the address-match type. The block turns these into one status byte per frame.

At the end of each frame the block decides whether the status byte goes into the frame's header in buffer memory. If it does, it raises a one-cycle write request that carries the byte. Two live bits in the same byte show whether the receiver is disabled by monitor mode and whether the line is deferring because of carrier, collision or jabber.

Alignment errors, CRC errors and missed frames each advance their own saturating counter. The host reads these through a small read port, and each read clears the counter it returns. The host therefore never has to watch the status byte frame by frame.

Top module: `rx_status_tally`

## Requirements
- R1: Status byte bits, from bit 0 up, are: intact(0), crc_err(1), align_err(2), overrun(3), missed(4), mcast(5), rx_off(6), defer(7). The intact bit is 1 only when bits 1 to 4 are all 0 for that frame.
- R2: At frame end, crc_bad=1 sets bit 1. crc_bad=1 together with misaligned=1 sets both bit 1 and bit 2. misaligned=1 with a good CRC is no error. The pair (bit2=1, bit1=0) never occurs.
- R3: fifo_ovf during a frame ends that frame at once with only the overrun bit (and mcast) set. A later pkt_end before the next pkt_start is ignored. So is a pkt_end seen outside any frame.
- R4: A frame is missed (bit 4) when buf_avail=0 or monitor_mode=1 at frame end.
- R5: Bit 5 copies mcast_hit at frame end: 0 is a physical match, 1 is a multicast match.
- R6: The cycle after a pkt_start that opens a frame, bits 0 to 5 read 0.
- R7: At frame end, wb_valid pulses for one cycle with wb_data equal to the new status byte. This happens when the frame is intact, or when save_err_mode=1 and the frame was not missed. Otherwise there is no pulse.
- R8: Bit 6 follows monitor_mode and bit 7 follows (carrier_sense | collision | jabber), each one cycle late. Bit 7 therefore stays 1 for as long as jabber is held.
- R9: Each frame with an alignment error advances tally 0. Each frame with a CRC error, including alignment errors, advances tally 1. Each missed frame advances tally 2.
- R10: A tally counter stops at its all-ones value (255 by default) and does not wrap.
- R11: A host read (rd_en=1) of tally rd_sel (0, 1 or 2) clears that counter at the clock edge. If it advances in the same cycle, it holds 1 afterwards. rd_sel=3 returns the status byte, and rd_data follows rd_sel without any clock.
- R12: After reset, all counters, the status byte and wb_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Frame start strobe |
| pkt_end | input | 1 | Frame end strobe |
| crc_bad | input | 1 | CRC mismatch at last byte boundary, valid with pkt_end |
| misaligned | input | 1 | Frame ended off a byte boundary, valid with pkt_end |
| fifo_ovf | input | 1 | Receive FIFO overflow, aborts the frame |
| buf_avail | input | 1 | A receive buffer is free, valid with pkt_end |
| mcast_hit | input | 1 | Multicast address match (0 = physical) |
| save_err_mode | input | 1 | Keep errored frames in memory |
| monitor_mode | input | 1 | Monitor mode, receiver does not buffer |
| carrier_sense | input | 1 | Carrier sense indication |
| collision | input | 1 | Collision indication |
| jabber | input | 1 | Transceiver jabber indication |
| rd_en | input | 1 | Host read strobe, clears the selected tally |
| rd_sel | input | 2 | Read select: 0..2 tallies, 3 status byte |
| rd_data | output | 8 | Read data (counter width, at least 8) |
| wb_valid | output | 1 | One-cycle status write-back request |
| wb_data | output | 8 | Status byte to write into the frame header |

## Verification
A wrong frame-state flag shows as a missing or extra write-back pulse, or as a status byte that changes on a stray end strobe. Either appears at the ports one cycle after the strobe. A wrong decode of the error conditions shows in the status byte and in wb_data in that same cycle. A wrong counter shows when the next host read returns a different value. The saturation and read-versus-increment cases are driven directly, because a single off-by-one there surfaces only at the all-ones value or on a coincident edge.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
   localparam int STAT_W    = 8;
   localparam int NUM_TALLY = 3;
   localparam int T_ALIGN   = 0;
   localparam int T_CRC     = 1;
   localparam int T_MISS    = 2;

   typedef struct packed {
      logic defer;
      logic rx_off;
      logic mcast;
      logic missed;
      logic overrun;
      logic align_err;
      logic crc_err;
      logic intact;
   } rx_stat_t;
endpackage

// File: rtl/rx_tally_ctr.sv
module rx_tally_ctr #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = '1;
   localparam logic [W-1:0] CNT_ONE = W'(1);

   logic [W-1:0] cnt_nxt;

   generate
      if (W < 2) begin : g_bad_width
         $error("rx_tally_ctr: W must be at least 2");
      end
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;
      end else begin : g_wrap
         assign cnt_nxt = cnt + CNT_ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= inc ? CNT_ONE : '0;
      else if (inc) cnt <= cnt_nxt;
   end

   // R11: read-clear keeps a coincident event
   assert_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == (W'($past(inc)))));

   generate
      if (SATURATE) begin : g_sat_chk
         // R10: all-ones value holds under further events
         assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
      end
   endgenerate
endmodule

// File: rtl/rx_stat_core.sv
module rx_stat_core
   import rx_stat_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pkt_start,
   input  logic                 pkt_end,
   input  logic                 crc_bad,
   input  logic                 misaligned,
   input  logic                 fifo_ovf,
   input  logic                 buf_avail,
   input  logic                 mcast_hit,
   input  logic                 save_err_mode,
   input  logic                 monitor_mode,
   input  logic                 carrier_sense,
   input  logic                 collision,
   input  logic                 jabber,
   output rx_stat_t             stat,
   output logic [NUM_TALLY-1:0] tally_inc,
   output logic                 wb_valid,
   output logic [STAT_W-1:0]    wb_data
);
   logic     in_pkt;
   logic     fin;
   logic     abort;
   logic     keep;
   rx_stat_t nxt;

   assign fin   = in_pkt & (pkt_end | fifo_ovf);
   assign abort = in_pkt & fifo_ovf;

   always_comb begin
      nxt           = stat;
      nxt.crc_err   = ~abort & crc_bad;
      nxt.align_err = ~abort & crc_bad & misaligned;
      nxt.overrun   = abort;
      nxt.missed    = ~abort & (~buf_avail | monitor_mode);
      nxt.mcast     = mcast_hit;
      nxt.intact    = ~(nxt.crc_err | nxt.align_err | nxt.overrun | nxt.missed);
   end

   assign keep = nxt.intact | (save_err_mode & ~nxt.missed);

   assign tally_inc[T_ALIGN] = fin & nxt.align_err;
   assign tally_inc[T_CRC]   = fin & nxt.crc_err;
   assign tally_inc[T_MISS]  = fin & nxt.missed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat     <= '0;
         in_pkt   <= 1'b0;
         wb_valid <= 1'b0;
         wb_data  <= '0;
      end else begin
         stat.rx_off <= monitor_mode;
         stat.defer  <= carrier_sense | collision | jabber;
         wb_valid    <= 1'b0;
         if (fin) begin
            stat.intact    <= nxt.intact;
            stat.crc_err   <= nxt.crc_err;
            stat.align_err <= nxt.align_err;
            stat.overrun   <= nxt.overrun;
            stat.missed    <= nxt.missed;
            stat.mcast     <= nxt.mcast;
            in_pkt         <= 1'b0;
            wb_valid       <= keep;
            wb_data        <= nxt;
         end else if (pkt_start) begin
            stat.intact    <= 1'b0;
            stat.crc_err   <= 1'b0;
            stat.align_err <= 1'b0;
            stat.overrun   <= 1'b0;
            stat.missed    <= 1'b0;
            stat.mcast     <= 1'b0;
            in_pkt         <= 1'b1;
         end
      end
   end

   assert_align_needs_crc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat.align_err |-> stat.crc_err);

   assert_intact_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stat.intact |-> !(stat.crc_err | stat.align_err | stat.overrun | stat.missed));

   assert_wb_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid);

   assert_rx_off_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |=> (stat.rx_off == $past(monitor_mode)));

   assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && !in_pkt) |=> (stat[5:0] == 6'd0));
endmodule

// File: rtl/rx_status_tally.sv
module rx_status_tally
   import rx_stat_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 pkt_start,
   input  logic                                 pkt_end,
   input  logic                                 crc_bad,
   input  logic                                 misaligned,
   input  logic                                 fifo_ovf,
   input  logic                                 buf_avail,
   input  logic                                 mcast_hit,
   input  logic                                 save_err_mode,
   input  logic                                 monitor_mode,
   input  logic                                 carrier_sense,
   input  logic                                 collision,
   input  logic                                 jabber,
   input  logic                                 rd_en,
   input  logic [1:0]                           rd_sel,
   output logic [((CNT_W > 8) ? CNT_W : 8)-1:0] rd_data,
   output logic                                 wb_valid,
   output logic [7:0]                           wb_data
);
   localparam int RD_W = (CNT_W > 8) ? CNT_W : 8;

   rx_stat_t             stat;
   logic [NUM_TALLY-1:0] tally_inc;
   logic [NUM_TALLY-1:0] tally_clr;
   logic [CNT_W-1:0]     tally [NUM_TALLY];

   rx_stat_core u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .pkt_start     (pkt_start),
      .pkt_end       (pkt_end),
      .crc_bad       (crc_bad),
      .misaligned    (misaligned),
      .fifo_ovf      (fifo_ovf),
      .buf_avail     (buf_avail),
      .mcast_hit     (mcast_hit),
      .save_err_mode (save_err_mode),
      .monitor_mode  (monitor_mode),
      .carrier_sense (carrier_sense),
      .collision     (collision),
      .jabber        (jabber),
      .stat          (stat),
      .tally_inc     (tally_inc),
      .wb_valid      (wb_valid),
      .wb_data       (wb_data)
   );

   generate
      for (genvar i = 0; i < NUM_TALLY; i++) begin : g_tally
         assign tally_clr[i] = rd_en && (rd_sel == 2'(i));
         rx_tally_ctr #(.W(CNT_W), .SATURATE(SATURATE)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (tally_inc[i]),
            .clr   (tally_clr[i]),
            .cnt   (tally[i])
         );
      end
   endgenerate

   always_comb begin
      case (rd_sel)
         2'd0:    rd_data = RD_W'(tally[T_ALIGN]);
         2'd1:    rd_data = RD_W'(tally[T_CRC]);
         2'd2:    rd_data = RD_W'(tally[T_MISS]);
         default: rd_data = RD_W'(stat);
      endcase
   end

   // R9: an alignment error always advances the CRC tally as well
   assert_align_also_crc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tally_inc[T_ALIGN] |-> tally_inc[T_CRC]);
endmodule

// File: tb/tb_rx_status_tally.sv
module tb_rx_status_tally;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pkt_start = 0, pkt_end = 0, crc_bad = 0, misaligned = 0, fifo_ovf = 0;
   logic buf_avail = 1, mcast_hit = 0, save_err_mode = 0, monitor_mode = 0;
   logic carrier_sense = 0, collision = 0, jabber = 0, rd_en = 0;
   logic [1:0] rd_sel = 2'd0;
   logic [7:0] rd_data;
   logic       wb_valid;
   logic [7:0] wb_data;

   int checks = 0;
   int errors = 0;
   int exp_t0 = 0, exp_t1 = 0, exp_t2 = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rx_status_tally dut (
      .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
      .crc_bad(crc_bad), .misaligned(misaligned), .fifo_ovf(fifo_ovf),
      .buf_avail(buf_avail), .mcast_hit(mcast_hit), .save_err_mode(save_err_mode),
      .monitor_mode(monitor_mode), .carrier_sense(carrier_sense),
      .collision(collision), .jabber(jabber), .rd_en(rd_en), .rd_sel(rd_sel),
      .rd_data(rd_data), .wb_valid(wb_valid), .wb_data(wb_data)
   );

   // {crc, misal, ovf, avail, mcast, save, exp_status[5:0], exp_wb}
   localparam logic [12:0] VEC [10] = '{
      {6'b000100, 6'h01, 1'b1},
      {6'b000110, 6'h21, 1'b1},
      {6'b100100, 6'h02, 1'b0},
      {6'b100101, 6'h02, 1'b1},
      {6'b110101, 6'h06, 1'b1},
      {6'b010100, 6'h01, 1'b1},
      {6'b000001, 6'h10, 1'b0},
      {6'b001101, 6'h08, 1'b1},
      {6'b001100, 6'h08, 1'b0},
      {6'b110111, 6'h26, 1'b1}
   };

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic peek(input logic [1:0] sel, output int val);
      rd_sel = sel;
      #1;
      val = int'(rd_data);
   endtask

   task automatic run_pkt(input logic c, input logic m, input logic o,
                          input logic av, input logic mc, input logic sv);
      @(negedge clk) pkt_start = 1;
      @(negedge clk) pkt_start = 0;
      crc_bad = c; misaligned = m; buf_avail = av; mcast_hit = mc; save_err_mode = sv;
      if (o) fifo_ovf = 1; else pkt_end = 1;
      @(negedge clk) pkt_end = 0; fifo_ovf = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      for (int s = 0; s < 4; s++) begin
         peek(2'(s), v);
         chk("R12 reset read", v, 0);
      end
      chk("R12 reset wb_valid", int'(wb_valid), 0);

      // vector table: R1 R2 R3 R4 R5 R7
      for (int i = 0; i < 10; i++) begin
         logic [12:0] e;
         e = VEC[i];
         run_pkt(e[12], e[11], e[10], e[9], e[8], e[7]);
         chk("R7 wb_valid", int'(wb_valid), int'(e[0]));
         if (e[0]) chk("R7 wb_data", int'(wb_data), int'({2'b00, e[6:1]}));
         peek(2'd3, v);
         chk("R1 R2 status", v, int'({2'b00, e[6:1]}));
         exp_t0 += int'(e[3]);
         exp_t1 += int'(e[2]);
         exp_t2 += int'(e[5]);
      end
      peek(2'd0, v); chk("R9 align tally", v, exp_t0);
      peek(2'd1, v); chk("R9 crc tally", v, exp_t1);

      // R6: opening a frame clears packet bits
      @(negedge clk) pkt_start = 1;
      @(negedge clk) pkt_start = 0;
      peek(2'd3, v); chk("R6 cleared on start", v, 0);
      @(negedge clk) pkt_end = 1; crc_bad = 0; buf_avail = 1; mcast_hit = 0;
      @(negedge clk) pkt_end = 0;

      // R3: overrun aborts; following end strobe ignored
      run_pkt(0, 0, 1, 1, 0, 1);
      @(negedge clk) pkt_end = 1; crc_bad = 1;
      @(negedge clk) pkt_end = 0; crc_bad = 0;
      chk("R3 stray end no wb", int'(wb_valid), 0);
      peek(2'd3, v); chk("R3 stray end status", v, 8'h08);
      peek(2'd1, v); chk("R3 stray end crc tally", v, exp_t1);

      // R8 and R4: monitor mode
      @(negedge clk) monitor_mode = 1;
      @(negedge clk);
      peek(2'd3, v); chk("R8 rx_off set", v & 8'h40, 8'h40);
      run_pkt(0, 0, 0, 1, 0, 1);
      chk("R4 monitor no wb", int'(wb_valid), 0);
      peek(2'd3, v); chk("R4 monitor missed", v, 8'h50);
      exp_t2++;
      @(negedge clk) monitor_mode = 0;
      @(negedge clk);
      peek(2'd3, v); chk("R8 rx_off clear", v & 8'h40, 0);

      // R8 defer
      @(negedge clk) carrier_sense = 1;
      @(negedge clk) carrier_sense = 0;
      peek(2'd3, v); chk("R8 defer on carrier", v & 8'h80, 8'h80);
      @(negedge clk);
      peek(2'd3, v); chk("R8 defer drops", v & 8'h80, 0);
      @(negedge clk) jabber = 1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         peek(2'd3, v); chk("R8 defer held by jabber", v & 8'h80, 8'h80);
      end
      jabber = 0;
      @(negedge clk);
      peek(2'd3, v); chk("R8 defer after jabber", v & 8'h80, 0);

      // R11 clear on read
      peek(2'd2, v); chk("R9 missed tally", v, exp_t2);
      @(negedge clk) rd_sel = 2'd2; rd_en = 1;
      @(negedge clk) rd_en = 0;
      peek(2'd2, v); chk("R11 cleared by read", v, 0);

      // R10 saturation
      for (int k = 0; k < 260; k++) run_pkt(0, 0, 0, 0, 0, 0);
      peek(2'd2, v); chk("R10 saturates", v, 255);

      // R11 read coincident with increment
      @(negedge clk) pkt_start = 1;
      @(negedge clk) pkt_start = 0;
      buf_avail = 0; pkt_end = 1; rd_en = 1; rd_sel = 2'd2;
      @(negedge clk) pkt_end = 0; rd_en = 0; buf_avail = 1;
      peek(2'd2, v); chk("R11 read with increment", v, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule